// File: doc/BRIEF.md
# Neighbour-Routed Dual Lookup-Table Logic Cell

This block is one programmable logic tile, meant to be repeated across a small two-dimensional array. It has two independent 4-input lookup tables, F and G. Both tables read the same four cell inputs. Each of those inputs is picked by a 3-bit selector from the eight F and G outputs of the four adjacent tiles (north, east, south, west). The F and G results leave the tile on `f_out` and `g_out`, so that neighbouring tiles can pick them up.

All configuration arrives as a serial bitstream. A 44-bit shift chain takes one bit per clock while `cfg_shift` is high, and it passes the oldest bit on through `cfg_next` to the next tile in the array. The array bitstream is therefore the concatenation of every tile's 44 bits. Once loading stops, the configuration holds until it is shifted again. The logic path from neighbour outputs to `f_out`/`g_out` is purely combinational.

The configuration interface is a plain enable-qualified shift with no handshake. It has no back-pressure: every clock with `cfg_shift` high consumes exactly one bit. A tile on the array boundary is built with `EDGE_MASK` set for each missing side, and it then reads constant 0 from those sources.

Top module: `nbr_logic_cell`

## Requirements
- R1: After reset every configuration bit is 0. With zero tables, `f_out`, `g_out` and `cfg_next` are all 0 whatever the neighbours drive.
- R2: On each rising clock with `cfg_shift` high, one bit from `cfg_bit` enters the chain. `cfg_next` shows the bit that entered 44 shifts earlier, so a second 44-bit load pushes the first load out in its original order.
- R3: While `cfg_shift` is low the configuration does not change, whatever `cfg_bit` does. The outputs and `cfg_next` stay as they were for the same neighbour values.
- R4: The bits of one tile's load are sent in this order. First come four 3-bit selector fields, for input 1, then 2, 3 and 4, each sent most significant bit first. Next come the 16 F table bits, sent from index 15 down to index 0. Last come the 16 G table bits in the same index order.
- R5: Selector codes map to sources as follows: 0 north F, 1 north G, 2 east F, 3 east G, 4 south G, 5 south F, 6 west F, 7 west G. Neighbour port bit 0 is north, 1 east, 2 south, 3 west.
- R6: A table output is the table bit at index {input4, input3, input2, input1}, with input 1 as the least significant index bit. Any 16-bit table realises its Boolean function.
- R7: F and G use the same four selected inputs but their own tables, so the two outputs differ exactly as their tables differ.
- R8: The outputs follow any change on the neighbour ports without a clock edge.
- R9: For each side whose `EDGE_MASK` bit is set (bit 0 north, 1 east, 2 south, 3 west), both of that side's sources read as 0, whatever the port carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears the configuration |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration bit in |
| cfg_next | output | 1 | Serial bit out to the next tile in the chain |
| nbr_f | input | 4 | F outputs of the neighbours, bit 0 north, 1 east, 2 south, 3 west |
| nbr_g | input | 4 | G outputs of the neighbours, same side order |
| f_out | output | 1 | F table result |
| g_out | output | 1 | G table result |

## Verification
The tile is first loaded with one routing (north F, east G, south F, west G) and two unrelated tables. All sixteen input indices are then swept, with the unused sources driven to the complement of the used ones. This separates a correct index order and a correct source choice from swapped inputs, reversed table order or F/G confusion. Each of the eight selector codes is then tried alone, with the chosen source driven high among low decoys and then low among high decoys, which pins down the code map. The same stimulus drives a boundary tile with north and south missing, which must read zeros there. A second load checks that the first bitstream comes out of the chain in order, and idle toggling of the serial input checks that the held configuration survives.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

  localparam int NLC_DIRS  = 4;
  localparam int NLC_SEL_W = 3;

  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;

  typedef enum logic [NLC_SEL_W-1:0] {
    SRC_N_F = 3'd0,
    SRC_N_G = 3'd1,
    SRC_E_F = 3'd2,
    SRC_E_G = 3'd3,
    SRC_S_G = 3'd4,
    SRC_S_F = 3'd5,
    SRC_W_F = 3'd6,
    SRC_W_G = 3'd7
  } src_code_e;

  function automatic logic [1:0] src_side(input logic [NLC_SEL_W-1:0] code);
    logic [1:0] side;
    case (src_code_e'(code))
      SRC_N_F, SRC_N_G: side = 2'(DIR_N);
      SRC_E_F, SRC_E_G: side = 2'(DIR_E);
      SRC_S_G, SRC_S_F: side = 2'(DIR_S);
      default:          side = 2'(DIR_W);
    endcase
    return side;
  endfunction

  function automatic logic src_is_g(input logic [NLC_SEL_W-1:0] code);
    logic is_g;
    case (src_code_e'(code))
      SRC_N_G, SRC_E_G, SRC_S_G, SRC_W_G: is_g = 1'b1;
      default:                            is_g = 1'b0;
    endcase
    return is_g;
  endfunction

endpackage

// File: rtl/nlc_cfg_chain.sv
module nlc_cfg_chain #(
  parameter int CFG_BITS = 44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic                bit_out,
  output logic [CFG_BITS-1:0] cfg
);

  logic [CFG_BITS-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {chain_q[CFG_BITS-2:0], bit_in};
    end
  end

  assign cfg     = chain_q;
  assign bit_out = chain_q[CFG_BITS-1];

  // R2: a shift captures the serial input at the bottom of the chain
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (chain_q[0] == $past(bit_in)));

  // R2: the outgoing bit is the one that sat one place below last cycle
  p_shift_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (bit_out == $past(chain_q[CFG_BITS-2])));

  // R3: no shift, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_q));

endmodule

// File: rtl/nlc_edge_guard.sv
module nlc_edge_guard
  import nlc_pkg::*;
#(
  parameter logic [NLC_DIRS-1:0] EDGE_MASK = '0
) (
  input  logic [NLC_DIRS-1:0] f_in,
  input  logic [NLC_DIRS-1:0] g_in,
  output logic [NLC_DIRS-1:0] f_o,
  output logic [NLC_DIRS-1:0] g_o
);

  for (genvar d = 0; d < NLC_DIRS; d++) begin : g_side
    if (EDGE_MASK[d]) begin : g_absent
      assign f_o[d] = 1'b0;
      assign g_o[d] = 1'b0;
    end else begin : g_present
      assign f_o[d] = f_in[d];
      assign g_o[d] = g_in[d];
    end
  end

endmodule

// File: rtl/nlc_src_mux.sv
module nlc_src_mux
  import nlc_pkg::*;
(
  input  logic [NLC_SEL_W-1:0] code,
  input  logic [NLC_DIRS-1:0]  side_f,
  input  logic [NLC_DIRS-1:0]  side_g,
  output logic                 sel_o
);

  logic [1:0] side;
  logic       want_g;

  always_comb begin
    side   = src_side(code);
    want_g = src_is_g(code);
    sel_o  = want_g ? side_g[side] : side_f[side];
  end

endmodule

// File: rtl/nlc_lut.sv
module nlc_lut #(
  parameter int K = 4,
  localparam int ROWS = 1 << K
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] table_bits,
  input  logic [K-1:0]    idx,
  output logic            y
);

  assign y = table_bits[idx];

  // R6: an all-zero table yields 0 for every index
  p_zero_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (table_bits == '0) |-> (y == 1'b0));

endmodule

// File: rtl/nbr_logic_cell.sv
module nbr_logic_cell
  import nlc_pkg::*;
#(
  parameter int                  LUT_K     = 4,
  parameter logic [NLC_DIRS-1:0] EDGE_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_shift,
  input  logic                cfg_bit,
  output logic                cfg_next,
  input  logic [NLC_DIRS-1:0] nbr_f,
  input  logic [NLC_DIRS-1:0] nbr_g,
  output logic                f_out,
  output logic                g_out
);

  localparam int TT_BITS  = 1 << LUT_K;
  localparam int SEL_BITS = LUT_K * NLC_SEL_W;
  localparam int CFG_BITS = SEL_BITS + 2 * TT_BITS;

  logic [CFG_BITS-1:0] cfg;
  logic [NLC_DIRS-1:0] side_f, side_g;
  logic [LUT_K-1:0]    lut_in;
  logic [TT_BITS-1:0]  f_table, g_table;

  nlc_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift),
    .bit_in   (cfg_bit),
    .bit_out  (cfg_next),
    .cfg      (cfg)
  );

  nlc_edge_guard #(.EDGE_MASK(EDGE_MASK)) u_edge (
    .f_in (nbr_f),
    .g_in (nbr_g),
    .f_o  (side_f),
    .g_o  (side_g)
  );

  // selector fields sit at the top of the chain, input 1 first in
  for (genvar k = 0; k < LUT_K; k++) begin : g_input
    logic [NLC_SEL_W-1:0] code_k;
    assign code_k = cfg[CFG_BITS-1-k*NLC_SEL_W -: NLC_SEL_W];

    nlc_src_mux u_mux (
      .code   (code_k),
      .side_f (side_f),
      .side_g (side_g),
      .sel_o  (lut_in[k])
    );

    // R9: a selector pointing at an absent side must deliver 0
    p_edge_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      EDGE_MASK[src_side(code_k)] |-> (lut_in[k] == 1'b0));
  end

  assign f_table = cfg[2*TT_BITS-1:TT_BITS];
  assign g_table = cfg[TT_BITS-1:0];

  nlc_lut #(.K(LUT_K)) u_lut_f (
    .clk        (clk),
    .rst_n      (rst_n),
    .table_bits (f_table),
    .idx        (lut_in),
    .y          (f_out)
  );

  nlc_lut #(.K(LUT_K)) u_lut_g (
    .clk        (clk),
    .rst_n      (rst_n),
    .table_bits (g_table),
    .idx        (lut_in),
    .y          (g_out)
  );

  // R8: with configuration idle and neighbours steady, outputs stay put
  p_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_shift) && $stable(nbr_f) && $stable(nbr_g))
      |-> ($stable(f_out) && $stable(g_out)));

endmodule

// File: tb/tb_nbr_logic_cell.sv
module tb_nbr_logic_cell;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_shift;
  logic       cfg_bit;
  logic [3:0] nbr_f, nbr_g;
  logic       cfg_next, f_out, g_out;
  logic       e_next, e_f, e_g;

  localparam logic [3:0] EMASK = 4'b0101;

  always #10 clk = ~clk;

  nbr_logic_cell dut (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .cfg_next(cfg_next), .nbr_f(nbr_f), .nbr_g(nbr_g),
    .f_out(f_out), .g_out(g_out)
  );

  nbr_logic_cell #(.EDGE_MASK(EMASK)) dut_edge (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .cfg_next(e_next), .nbr_f(nbr_f), .nbr_g(nbr_g),
    .f_out(e_f), .g_out(e_g)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  event       drv_ev;
  logic [43:0] cur_cfg;

  // source pick per R5 and R9
  function automatic logic pick(input logic [2:0] c, input logic [3:0] nf,
                                input logic [3:0] ng, input logic [3:0] mask);
    int side;
    logic is_g;
    case (c)
      3'd0: begin side = 0; is_g = 1'b0; end
      3'd1: begin side = 0; is_g = 1'b1; end
      3'd2: begin side = 1; is_g = 1'b0; end
      3'd3: begin side = 1; is_g = 1'b1; end
      3'd4: begin side = 2; is_g = 1'b1; end
      3'd5: begin side = 2; is_g = 1'b0; end
      3'd6: begin side = 3; is_g = 1'b0; end
      default: begin side = 3; is_g = 1'b1; end
    endcase
    if (mask[side]) return 1'b0;
    return is_g ? ng[side] : nf[side];
  endfunction

  // {f, g} per R4, R6, R7
  function automatic logic [1:0] model(input logic [43:0] c, input logic [3:0] nf,
                                       input logic [3:0] ng, input logic [3:0] mask);
    logic [3:0] idx;
    for (int k = 0; k < 4; k++) idx[k] = pick(c[43-3*k -: 3], nf, ng, mask);
    return {c[16 + idx], c[idx]};
  endfunction

  function automatic logic [43:0] mk(input logic [2:0] s1, input logic [2:0] s2,
                                     input logic [2:0] s3, input logic [2:0] s4,
                                     input logic [15:0] ft, input logic [15:0] gt);
    return {s1, s2, s3, s4, ft, gt};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic load(input logic [43:0] v);
    for (int i = 43; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_bit   = v[i];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cur_cfg   = v;
  endtask

  task automatic load_capture(input logic [43:0] v, output logic [43:0] cap);
    for (int i = 43; i >= 0; i--) begin
      @(negedge clk);
      cap[i]    = cfg_next;
      cfg_shift = 1'b1;
      cfg_bit   = v[i];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cur_cfg   = v;
  endtask

  // driver: apply neighbours, push expectation for both tiles
  task automatic drive(input logic [3:0] nf, input logic [3:0] ng, input string tag);
    @(negedge clk);
    nbr_f = nf;
    nbr_g = ng;
    exp_q.push_back({model(cur_cfg, nf, ng, 4'b0000), model(cur_cfg, nf, ng, EMASK)});
    tag_q.push_back(tag);
    -> drv_ev;
  endtask

  // monitor: compare once the combinational path has settled, no clock edge between
  initial begin
    forever begin
      @(drv_ev);
      #2;
      while (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'({f_out, g_out, e_f, e_g}), 32'(e));
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [43:0] cfg_a, cfg_b, cap;
    rst_n = 1'b0; cfg_shift = 1'b0; cfg_bit = 1'b0;
    nbr_f = 4'hF; nbr_g = 4'hF;
    cur_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: cleared configuration gives zeros
    check("R1 reset outputs", 32'({f_out, g_out, cfg_next, e_f, e_g, e_next}), 32'd0);

    // R4 R6 R7 R8: routing N.F, E.G, S.F, W.G with two tables, full index sweep
    cfg_a = mk(3'd0, 3'd3, 3'd5, 3'd7, 16'hA5C3, 16'h3C96);
    load(cfg_a);
    for (int j = 0; j < 16; j++) begin
      logic [3:0] jj, nf, ng;
      jj = 4'(j);
      nf = {~jj[3], jj[2], ~jj[1], jj[0]};
      ng = {jj[3], ~jj[2], jj[1], ~jj[0]};
      drive(nf, ng, $sformatf("R6 R7 R8 index sweep j=%0d", j));
    end

    // R3: idle toggling of the serial input leaves everything intact
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      cfg_bit = ~cfg_bit;
    end
    @(negedge clk);
    check("R3 chain output held", 32'(cfg_next), 32'(cfg_a[43]));
    drive(4'b1001, 4'b0110, "R3 held config index");
    drive(4'b0110, 4'b1001, "R3 held config index 2");

    // R2: a second load pushes the first one out in order
    cfg_b = mk(3'd6, 3'd4, 3'd1, 3'd2, 16'h6996, 16'h0F0F);
    load_capture(cfg_b, cap);
    check("R2 shifted-out bitstream", 32'(cap[43:32]), 32'(cfg_a[43:32]));
    check("R2 shifted-out tables", cap[31:0], cfg_a[31:0]);
    for (int j = 0; j < 8; j++) begin
      logic [3:0] jj;
      jj = 4'(j * 3 + 1);
      drive(jj, ~{jj[0], jj[3], jj[1], jj[2]}, $sformatf("R4 second routing j=%0d", j));
    end

    // R5 R9: each selector code alone on input 1, F follows input 1, G inverts it
    for (int c = 0; c < 8; c++) begin
      logic [3:0] hf, hg;
      load(mk(3'(c), 3'd0, 3'd0, 3'd0, 16'hAAAA, 16'h5555));
      hf = 4'b0000; hg = 4'b0000;
      case (c)
        0: hf[0] = 1'b1;
        1: hg[0] = 1'b1;
        2: hf[1] = 1'b1;
        3: hg[1] = 1'b1;
        4: hg[2] = 1'b1;
        5: hf[2] = 1'b1;
        6: hf[3] = 1'b1;
        default: hg[3] = 1'b1;
      endcase
      drive(hf, hg, $sformatf("R5 R9 code %0d high among low", c));
      drive(~hf, ~hg, $sformatf("R5 R9 code %0d low among high", c));
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule